// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit configuration words from a three-wire serial EEPROM. The host side has a start strobe with a word address, a busy level and a one-cycle done strobe. The done strobe comes with the fetched word and an error flag. The device side drives chip select, a serial clock and the serial data line into the EEPROM, and it samples the EEPROM's serial data output.

The address length is not fixed when the block is built. The first access after reset is a discovery access. It sends the start bit and the read opcode, then sends zero address bits one at a time. The discovered width is the number of zero bits sent when the EEPROM answers with a 0. That width is stored and reported, and later accesses send exactly that many address bits. The discovery access returns word 0. If no 0 is seen within eight address bits, the access ends with an error, and the next start tries discovery again.

Each access ends with chip select low for a fixed quiet interval. The done strobe follows that interval, so the host is told the result only once the device is ready for the next command.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, busy_o, done_o, err_o, cs_o and sk_o are 0, and aw_o is 0, which means the width is unknown.
- R2: When busy_o is low, a start_i high is accepted, and busy_o is high in the next cycle. busy_o stays high until the cycle in which done_o is high, and in that cycle it is low. A start_i that is high in the done_o cycle is accepted.
- R3: A start_i received while busy_o is high has no effect. It produces no extra done_o, and it does not change the word or the address of the access in progress.
- R4: Every access raises cs_o before the first sk_o rise, and cs_o stays high until the last data bit. Each access sends, MSB first, a start bit of 1 followed by the read opcode 1 then 0. cs_o is high only while busy_o is high.
- R5: di_o changes only while sk_o is low. do_i is sampled in the last system cycle of each high phase of sk_o.
- R6: sk_o has a period of CLK_DIV system cycles, with a low half followed by a high half. sk_o is high only while cs_o is high.
- R7: The first access after reset sends zero address bits until do_i reads 0. The count of address bits sent is stored and shown on aw_o, and that access returns word 0.
- R8: Once aw_o is non-zero, an access sends the low aw_o bits of addr_i, MSB first, and returns that word. Address bits at or above aw_o are ignored.
- R9: After the address, 16 data bits are read MSB first. done_o is high for exactly one cycle, and rdata_o carries the word from that cycle until the next done_o.
- R10: If do_i is still 1 after MAX_AW address bits of a discovery access, the access aborts. done_o comes with err_o high and rdata_o equal to 0, and aw_o stays 0. err_o is never high without done_o.
- R11: After each access, cs_o stays low for at least 2*CLK_DIV system cycles before done_o, and also before any later rise of cs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Request one word read |
| addr_i | input | MAX_AW | Word address, low bits used |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | With done_o: discovery found no device |
| rdata_o | output | WORD_W | Word from the last completed access |
| aw_o | output | $clog2(MAX_AW+1) | Discovered address width, 0 if unknown |
| cs_o | output | 1 | EEPROM chip select, active high |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data into the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
The completion strobe of one access and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start_i in the very cycle it sees done_o. It then checks that busy_o rises at once and that the scoreboard receives both words in order, with the second word taken from the new address. A second case places a start request in the middle of a busy access. That request must leave no trace: the done count, the scoreboard and the returned word must match the first address alone. A bench model of the EEPROM with a selectable address width, or with no device present, judges the framing and supplies the words.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_GAP
    } mw_state_e;

    // start bit, then read opcode, MSB first on the wire
    localparam int          CMD_BITS = 3;
    localparam logic [1:0]  RD_OPC   = 2'b10;

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sk_o,
    output logic last_o
);
    localparam int PH_W = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (!run_i || ph_q == PH_W'(DIV - 1)) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign sk_o   = run_i && (ph_q >= PH_W'(HALF));
    assign last_o = run_i && (ph_q == PH_W'(DIV - 1));

endmodule

// File: rtl/mw_gap_timer.sv
module mw_gap_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int CW = $clog2(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          act_d, act_q;

    always_comb begin
        cnt_d = cnt_q;
        act_d = act_q;
        if (load_i) begin
            cnt_d = CW'(CYCLES - 1);
            act_d = 1'b1;
        end else if (act_q) begin
            if (cnt_q == '0) begin
                act_d = 1'b0;
            end else begin
                cnt_d = cnt_q - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            act_q <= act_d;
        end
    end

    assign expire_o = act_q && (cnt_q == '0);

endmodule

// File: rtl/mw_addr_pick.sv
module mw_addr_pick #(
    parameter int AW   = 8,
    parameter int IX_W = 4
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [IX_W-1:0] idx_i,
    output logic            bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < AW; i++) begin
            if (idx_i == IX_W'(i)) begin
                bit_o = addr_i[i];
            end
        end
    end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_eeprom_pkg::*;
#(
    parameter int CLK_DIV     = 8,
    parameter int MAX_AW      = 8,
    parameter int WORD_W      = 16,
    parameter int GAP_PERIODS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [MAX_AW-1:0]             addr_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          err_o,
    output logic [WORD_W-1:0]             rdata_o,
    output logic [$clog2(MAX_AW+1)-1:0]   aw_o,
    output logic                          cs_o,
    output logic                          sk_o,
    output logic                          di_o,
    input  logic                          do_i
);
    localparam int AW_W    = $clog2(MAX_AW + 1);
    localparam int BC_MAX  = (WORD_W > MAX_AW) ? WORD_W : MAX_AW;
    localparam int BC_W    = $clog2(BC_MAX + 1);
    localparam int GAP_CYC = GAP_PERIODS * CLK_DIV;

    typedef struct packed {
        mw_state_e           st;
        logic [BC_W-1:0]     bitcnt;
        logic [WORD_W-1:0]   shreg;
        logic [MAX_AW-1:0]   addr;
        logic [AW_W-1:0]     aw;
        logic                detect;
        logic                err;
        logic                cs;
        logic                run;
        logic                di;
        logic                done;
        logic                done_err;
        logic [WORD_W-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic            bit_last;
    logic            gap_expire;
    logic            gap_load;
    logic [AW_W-1:0] pick_idx;
    logic            pick_bit;

    mw_sk_gen #(.DIV(CLK_DIV)) u_sk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.run),
        .sk_o   (sk_o),
        .last_o (bit_last)
    );

    mw_gap_timer #(.CYCLES(GAP_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (gap_load),
        .expire_o (gap_expire)
    );

    mw_addr_pick #(.AW(MAX_AW), .IX_W(AW_W)) u_pick (
        .addr_i (r_q.addr),
        .idx_i  (pick_idx),
        .bit_o  (pick_bit)
    );

    // index of the address bit to present next
    always_comb begin
        if (r_q.st == ST_ADDR) begin
            pick_idx = r_q.aw - AW_W'(2) - AW_W'(r_q.bitcnt);
        end else begin
            pick_idx = r_q.aw - AW_W'(1);
        end
    end

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.done_err = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_CMD;
                    r_d.cs     = 1'b1;
                    r_d.run    = 1'b1;
                    r_d.di     = 1'b1;
                    r_d.bitcnt = '0;
                    r_d.addr   = addr_i;
                    r_d.detect = (r_q.aw == '0);
                    r_d.err    = 1'b0;
                    r_d.shreg  = {RD_OPC, (WORD_W - 2)'(0)};
                end
            end
            ST_CMD: begin
                if (bit_last) begin
                    if (r_q.bitcnt == BC_W'(CMD_BITS - 1)) begin
                        r_d.st     = ST_ADDR;
                        r_d.bitcnt = '0;
                        r_d.shreg  = '0;
                        r_d.di     = r_q.detect ? 1'b0 : pick_bit;
                    end else begin
                        r_d.bitcnt = r_q.bitcnt + BC_W'(1);
                        r_d.di     = r_q.shreg[WORD_W-1];
                        r_d.shreg  = {r_q.shreg[WORD_W-2:0], 1'b0};
                    end
                end
            end
            ST_ADDR: begin
                if (bit_last) begin
                    if (r_q.detect) begin
                        if (!do_i) begin
                            r_d.aw     = AW_W'(r_q.bitcnt) + AW_W'(1);
                            r_d.st     = ST_DATA;
                            r_d.bitcnt = '0;
                            r_d.di     = 1'b0;
                        end else if (r_q.bitcnt == BC_W'(MAX_AW - 1)) begin
                            r_d.st  = ST_GAP;
                            r_d.cs  = 1'b0;
                            r_d.run = 1'b0;
                            r_d.err = 1'b1;
                            r_d.di  = 1'b0;
                        end else begin
                            r_d.bitcnt = r_q.bitcnt + BC_W'(1);
                            r_d.di     = 1'b0;
                        end
                    end else begin
                        if (r_q.bitcnt == BC_W'(r_q.aw) - BC_W'(1)) begin
                            r_d.st     = ST_DATA;
                            r_d.bitcnt = '0;
                            r_d.di     = 1'b0;
                        end else begin
                            r_d.bitcnt = r_q.bitcnt + BC_W'(1);
                            r_d.di     = pick_bit;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (bit_last) begin
                    r_d.shreg = {r_q.shreg[WORD_W-2:0], do_i};
                    if (r_q.bitcnt == BC_W'(WORD_W - 1)) begin
                        r_d.st  = ST_GAP;
                        r_d.cs  = 1'b0;
                        r_d.run = 1'b0;
                    end else begin
                        r_d.bitcnt = r_q.bitcnt + BC_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (gap_expire) begin
                    r_d.st       = ST_IDLE;
                    r_d.done     = 1'b1;
                    r_d.done_err = r_q.err;
                    r_d.rdata    = r_q.err ? '0 : r_q.shreg;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    assign gap_load = (r_q.st != ST_GAP) && (r_d.st == ST_GAP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = r_q.done;
    assign err_o   = r_q.done_err;
    assign rdata_o = r_q.rdata;
    assign aw_o    = r_q.aw;
    assign cs_o    = r_q.cs;
    assign di_o    = r_q.di;

endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
    parameter int CLK_DIV     = 8,
    parameter int MAX_AW      = 8,
    parameter int GAP_PERIODS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        busy_o,
    input logic                        done_o,
    input logic                        err_o,
    input logic [$clog2(MAX_AW+1)-1:0] aw_o,
    input logic                        cs_o,
    input logic                        sk_o,
    input logic                        di_o
);
    localparam int GAP_CYC = GAP_PERIODS * CLK_DIV;
    localparam int LW      = $clog2(GAP_CYC + 1);

    logic [LW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= LW'(GAP_CYC);
        end else if (cs_o) begin
            low_q <= '0;
        end else if (low_q != LW'(GAP_CYC)) begin
            low_q <= low_q + LW'(1);
        end
    end

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_cs_within_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> busy_o);

    p_di_moves_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (di_o != $past(di_o)) |-> !sk_o);

    p_sk_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    p_aw_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aw_o <= ($clog2(MAX_AW+1))'(MAX_AW));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_only_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    p_quiet_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && !$past(cs_o)) |-> ($past(low_q) == LW'(GAP_CYC)));

endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(
    .CLK_DIV     (CLK_DIV),
    .MAX_AW      (MAX_AW),
    .GAP_PERIODS (GAP_PERIODS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .aw_o    (aw_o),
    .cs_o    (cs_o),
    .sk_o    (sk_o),
    .di_o    (di_o)
);

// File: tb/test_mw_eeprom_reader.sv
module test_mw_eeprom_reader;
    localparam int DIV  = 8;
    localparam int MAW  = 8;
    localparam int WW   = 16;
    localparam int AWW  = $clog2(MAW + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [MAW-1:0]  addr_i = '0;
    logic            busy_o, done_o, err_o, cs_o, sk_o, di_o;
    logic [WW-1:0]   rdata_o;
    logic [AWW-1:0]  aw_o;
    logic            dev_do = 1'b1;

    always #2 clk = ~clk;

    mw_eeprom_reader #(.CLK_DIV(DIV), .MAX_AW(MAW), .WORD_W(WW), .GAP_PERIODS(2)) i_mw_eeprom_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
        .aw_o(aw_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(dev_do)
    );

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] memf(input logic [7:0] a);
        return {a ^ 8'hC3, ~a};
    endfunction

    // ---------------- EEPROM model ----------------
    int             dev_aw = 6;
    int             dstate = 0;
    int             dcnt = 0;
    logic [1:0]     dop;
    logic [7:0]     da;
    logic [15:0]    dw;
    int             bad_cmd = 0;
    int             cmd_seen = 0;

    always @(posedge sk_o or negedge cs_o) begin
        if (!cs_o) begin
            dstate = 0;
            dev_do = 1'b1;
        end else begin
            case (dstate)
                0: if (di_o) begin dstate = 1; dcnt = 0; dop = 2'b00; end
                1: begin
                    dop = {dop[0], di_o};
                    dcnt++;
                    if (dcnt == 2) begin
                        cmd_seen++;
                        if (dop != 2'b10) bad_cmd++;
                        dstate = 2; dcnt = 0; da = '0;
                    end
                end
                2: if (dev_aw > 0) begin
                    da = {da[6:0], di_o};
                    dcnt++;
                    if (dcnt == dev_aw) begin
                        dev_do = 1'b0;
                        dw = memf(da);
                        dstate = 3; dcnt = 0;
                    end
                end
                3: begin
                    dev_do = dw[15-dcnt];
                    dcnt++;
                    if (dcnt == 16) dstate = 4;
                end
                default: dev_do = 1'b1;
            endcase
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0]    data;
        logic           err;
        logic [AWW-1:0] aw;
    } exp_t;
    exp_t sbq[$];
    int   tb_aw = 0;
    int   dones = 0;
    int   issued = 0;

    task automatic push_exp(input logic [7:0] a);
        exp_t e;
        if (tb_aw == 0) begin
            if (dev_aw >= 1 && dev_aw <= MAW) begin
                e.data = memf(8'h00); e.err = 1'b0; e.aw = AWW'(dev_aw);
                tb_aw = dev_aw;
            end else begin
                e.data = '0; e.err = 1'b1; e.aw = '0;
            end
        end else begin
            e.data = memf(a & 8'((1 << tb_aw) - 1));
            e.err = 1'b0; e.aw = AWW'(tb_aw);
        end
        sbq.push_back(e);
        issued++;
    endtask

    task automatic issue(input logic [7:0] a);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; addr_i = a;
        push_exp(a);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2 busy after start", busy_o, 1);
    endtask

    // monitor, sk timing and quiet-gap bookkeeping
    int  cyc = 0;
    int  last_rise = -1;
    int  sk_bad = 0;
    int  sk_meas = 0;
    int  low_run = 0;
    bit  sk_prev = 0;
    bit  done_prev = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            last_rise = -1; sk_prev = 0; done_prev = 0; low_run = 0;
        end else begin
            if (cs_o) low_run = 0; else low_run++;
            if (!cs_o) last_rise = -1;
            if (sk_o && !sk_prev) begin
                if (last_rise >= 0) begin
                    sk_meas++;
                    if (cyc - last_rise != DIV) sk_bad++;
                end
                last_rise = cyc;
            end
            sk_prev = sk_o;
            if (done_o) begin
                exp_t e;
                dones++;
                chk(!done_prev, "R9 done one cycle", done_prev, 0);
                chk(low_run >= 2 * DIV + 1, "R11 quiet gap before done", low_run, 2 * DIV + 1);
                if (sbq.size() == 0) begin
                    chk(0, "R3 unexpected done", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    chk(rdata_o == e.data, "R9 word", rdata_o, e.data);
                    chk(err_o == e.err, "R10 error flag", err_o, e.err);
                    chk(aw_o == e.aw, "R7 width", aw_o, e.aw);
                end
            end
            done_prev = done_o;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tb_aw = 0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o || sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        dev_aw = 6;
        do_reset();
        // R1 reset state
        chk(!busy_o, "R1 busy", busy_o, 0);
        chk(!done_o && !err_o, "R1 done/err", {done_o, err_o}, 0);
        chk(!cs_o && !sk_o, "R1 cs/sk", {cs_o, sk_o}, 0);
        chk(aw_o == '0, "R1 width unknown", aw_o, 0);

        // R7 discovery on a 64-word device, then R8 reads
        issue(8'h2A);
        wait_idle();
        chk(aw_o == 6, "R7 width after discovery", aw_o, 6);
        issue(8'h2A);
        issue(8'h3F);
        issue(8'h01);
        issue(8'hC5);              // R8 upper bits ignored
        wait_idle();

        // R3 start while busy ignored
        issue(8'h11);
        repeat (60) @(negedge clk);
        chk(busy_o, "R3 still busy", busy_o, 1);
        start_i = 1'b1; addr_i = 8'h22;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(dones == issued, "R3 done count", dones, issued);

        // R2 start in the done cycle
        issue(8'h07);
        while (!done_o) @(negedge clk);
        start_i = 1'b1; addr_i = 8'h30;
        push_exp(8'h30);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2 start in done cycle", busy_o, 1);
        wait_idle();

        // 256-word device
        dev_aw = 8;
        do_reset();
        issue(8'h55);
        issue(8'hFF);
        issue(8'h80);
        wait_idle();
        chk(aw_o == 8, "R7 width 8", aw_o, 8);

        // 16-word device, R8 masking
        dev_aw = 4;
        do_reset();
        issue(8'h00);
        issue(8'hFD);
        issue(8'h0A);
        wait_idle();
        chk(aw_o == 4, "R7 width 4", aw_o, 4);

        // R10 absent device then retry
        dev_aw = 0;
        do_reset();
        issue(8'h12);
        wait_idle();
        chk(aw_o == '0, "R10 width stays unknown", aw_o, 0);
        chk(rdata_o == '0, "R10 word zero", rdata_o, 0);
        dev_aw = 8;
        issue(8'h12);
        issue(8'h9C);
        wait_idle();
        chk(aw_o == 8, "R10 retry discovers", aw_o, 8);

        // final bookkeeping
        chk(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 0);
        chk(dones == issued, "R3 total dones", dones, issued);
        chk(bad_cmd == 0, "R4 start bit and opcode", bad_cmd, 0);
        chk(cmd_seen == issued, "R4 commands framed", cmd_seen, issued);
        chk(sk_meas > 0 && sk_bad == 0, "R6 serial clock period", sk_bad, 0);
        chk(sk_meas > 0, "R5 sampling observed", sk_meas, 1);
        finish_run();
    end

endmodule